// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the software-visible register front end of a single bus-master DMA channel for a disk controller. A host reaches it through a small byte-addressed register port. It holds a command byte with a start bit and a transfer-direction bit, a status byte, and a 32-bit pointer to the descriptor table in host memory. The descriptor walker and the data mover are not part of this block.

When software turns the start bit on, the block copies the table pointer into the walker's fetch pointer. If no transfer is already running, it also sends the walker a one-cycle start pulse and marks the channel active. Turning start off does not stop a running transfer. The channel stays active until the walker reports that it has finished. The device interrupt is passed straight through to the host, and each rising edge of it is also recorded in a status bit that software can clear.

Top module: `bmd_regs`

## Requirements
- R1: A write to offset 0 keeps only bit 0 (start) and bit 3 (direction). Reading offset 0 returns those two bits and zero in every other bit. `walk_dir` always shows the stored bit 3.
- R2: A command write whose bit 0 equals the stored start bit sends no start pulse, leaves `walk_ptr` unchanged and leaves the active flag unchanged. Only the stored command byte is updated.
- R3: A command write that changes the start bit from 0 to 1 loads `walk_ptr` from the table pointer. If the active flag (status bit 0) was clear, the same write sets it, and `walk_start` is high for exactly the one cycle after that write edge. If the active flag was already set, no pulse is sent.
- R4: A command write that changes the start bit from 1 to 0 leaves the active flag set. The flag clears only in the cycle after `walk_done` is sampled high.
- R5: The table pointer occupies offsets 4 to 7. A write there uses `reg_size` (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes), with write data aligned to bit 0. It changes only the byte lanes from the offset up to the offset plus the width, stopping at lane 3. Bits 1:0 of the pointer always stay zero.
- R6: A read at offset 4+k returns the pointer shifted right by 8k bits and masked to the access width.
- R7: `host_irq` equals `dev_irq` in the same cycle. A rising edge of `dev_irq` sets status bit 2. A falling edge does not change status bit 2.
- R8: A status write at offset 2 clears bit 1 and bit 2 wherever the written byte has a 1. Bits 5 and 6 take the written values. Bit 0 cannot be written. Bits 3, 4 and 7 always read as zero.
- R9: When `walk_err` is sampled high, status bit 1 is set. If a clear of bit 1 arrives in the same cycle, the set wins.
- R10: A synchronous reset clears the command byte, the status byte, the table pointer and `walk_ptr`, and cancels any active transfer. Offsets 1 and 3 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_size | input | 2 | Access width code |
| reg_wdata | input | 32 | Write data, aligned to bit 0 |
| reg_rdata | output | 32 | Read data for `reg_addr`/`reg_size` (combinational) |
| walk_start | output | 1 | One-cycle start pulse to the walker |
| walk_dir | output | 1 | Stored direction bit |
| walk_ptr | output | 32 | Descriptor fetch pointer |
| walk_done | input | 1 | Walker reports transfer complete |
| walk_err | input | 1 | Walker reports an error |
| dev_irq | input | 1 | Device interrupt level |
| host_irq | output | 1 | Interrupt forwarded to the host |

## Verification
Register writes take effect at the clock edge that samples them. A read-back, `walk_ptr`, `walk_dir` and the start pulse can therefore be checked in the cycle that follows, and the bench samples them half a period after that edge. Reads are combinational from the registers, so the bench sets the read address, waits a short delay and samples within the same low phase. `host_irq` is checked that same way, right after `dev_irq` changes. Its status bit is checked one edge later, as is the clearing of the active flag after `walk_done`.

// File: rtl/bmd_pkg.sv
// Shared constants and helpers for the bus-master DMA register front end.
// Assumes a 32-bit table pointer spread over four byte lanes.
package bmd_pkg;
    localparam int PTR_W   = 32;
    localparam int LANES   = PTR_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int ADDR_W  = 3;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;
    localparam logic [7:0] CMD_KEEP = 8'h09;

    // Lane mask of an access for a given width code, before any offset.
    function automatic logic [LANES-1:0] width_lanes(input logic [1:0] code);
        case (code)
            2'd0:    width_lanes = 4'b0001;
            2'd1:    width_lanes = 4'b0011;
            default: width_lanes = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/bmd_ptr_reg.sv
// Descriptor table pointer with byte-lane writes and shifted reads.
// Assumes write data is aligned to bit 0; lanes beyond the top are dropped.
module bmd_ptr_reg
    import bmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFF_W-1:0]    off,
    input  logic [1:0]          size,
    input  logic [PTR_W-1:0]    wdata,
    output logic [PTR_W-1:0]    rdata,
    output logic [PTR_W-1:0]    ptr
);
    logic [LANES-1:0] lane_sel;
    logic [PTR_W-1:0] wshift;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] rmask;

    // Select the byte lanes touched by this access.
    always_comb lane_sel = width_lanes(size) << off;
    // Move write data up to the addressed lane.
    always_comb wshift = wdata << (8 * off);

    // Per-lane register update; bits 1:0 held at zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[8*g +: 8] <= '0;
            end else if (wr_en && lane_sel[g]) begin
                if (g == 0) ptr_q[8*g +: 8] <= wshift[8*g +: 8] & 8'hFC;
                else        ptr_q[8*g +: 8] <= wshift[8*g +: 8];
            end
        end
    end

    // Read: shift down by the offset and mask to the access width.
    always_comb begin
        for (int b = 0; b < LANES; b++)
            rmask[8*b +: 8] = {8{width_lanes(size)[b]}};
        rdata = (ptr_q >> (8 * off)) & rmask;
    end

    assign ptr = ptr_q;

    // R5: a write that misses lane 0 leaves lane 0 unchanged.
    assert_lane0_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lane_sel[0]) |=> $stable(ptr_q[7:0]));
endmodule

// File: rtl/bmd_ctrl.sv
// Command and status registers, start sequencing and interrupt capture.
// Assumes the walker raises walk_done only while a transfer is active.
module bmd_ctrl
    import bmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             stat_wr,
    input  logic [7:0]       wbyte,
    input  logic [PTR_W-1:0] base,
    input  logic             walk_done,
    input  logic             walk_err,
    input  logic             dev_irq,
    output logic [7:0]       cmd,
    output logic [7:0]       status,
    output logic             walk_start,
    output logic [PTR_W-1:0] walk_ptr
);
    logic [7:0]       cmd_q;
    logic             active_q, err_q, int_q, irq_q, pulse_q;
    logic [1:0]       drv_q;
    logic [PTR_W-1:0] ptr_q;
    logic             rise;

    // Start bit goes 0 to 1 on this command write.
    always_comb rise = cmd_wr && wbyte[0] && !cmd_q[0];

    // Command byte, fetch pointer, start pulse and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            ptr_q    <= '0;
            pulse_q  <= 1'b0;
            active_q <= 1'b0;
        end else begin
            pulse_q <= rise && !active_q;
            if (cmd_wr) cmd_q <= wbyte & CMD_KEEP;
            if (rise)   ptr_q <= base;
            if (rise && !active_q) active_q <= 1'b1;
            else if (walk_done)    active_q <= 1'b0;
        end
    end

    // Error, interrupt and drive-capable status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            int_q <= 1'b0;
            drv_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= dev_irq;
            if (walk_err)                err_q <= 1'b1;
            else if (stat_wr && wbyte[1]) err_q <= 1'b0;
            if (dev_irq && !irq_q)        int_q <= 1'b1;
            else if (stat_wr && wbyte[2]) int_q <= 1'b0;
            if (stat_wr) drv_q <= wbyte[6:5];
        end
    end

    assign cmd        = cmd_q;
    assign status     = {1'b0, drv_q, 2'b00, int_q, err_q, active_q};
    assign walk_start = pulse_q;
    assign walk_ptr   = ptr_q;

    // R3: the start pulse lasts one cycle and comes with the active flag.
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |=> !walk_start);
    assert_pulse_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |-> status[0]);
    // R2: rewriting the same start value never pulses.
    assert_same_start_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (wbyte[0] == cmd[0])) |=> !walk_start);
    // R4: completion drops the active flag.
    assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && status[0]) |=> !status[0]);
    // R7: a rising device interrupt latches status bit 2.
    assert_irq_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_irq) |=> status[2]);
    // R9: a walker error always lands in bit 1.
    assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        walk_err |=> status[1]);
endmodule

// File: rtl/bmd_regs.sv
// Register front end of one bus-master DMA channel: decodes the register
// port, routes writes, muxes reads and forwards the interrupt.
// Assumes reads are combinational and writes take effect at the clock edge.
module bmd_regs
    import bmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [1:0]  reg_size,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        walk_start,
    output logic        walk_dir,
    output logic [31:0] walk_ptr,
    input  logic        walk_done,
    input  logic        walk_err,
    input  logic        dev_irq,
    output logic        host_irq
);
    logic             cmd_wr, stat_wr, ptr_wr;
    logic [7:0]       cmd, status;
    logic [PTR_W-1:0] ptr_rd, base;

    // Address decode for writes.
    always_comb begin
        cmd_wr  = reg_wr && (reg_addr == OFS_CMD);
        stat_wr = reg_wr && (reg_addr == OFS_STAT);
        ptr_wr  = reg_wr && reg_addr[2];
    end

    bmd_ptr_reg u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ptr_wr),
        .off   (reg_addr[OFF_W-1:0]),
        .size  (reg_size),
        .wdata (reg_wdata),
        .rdata (ptr_rd),
        .ptr   (base)
    );

    bmd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .stat_wr    (stat_wr),
        .wbyte      (reg_wdata[7:0]),
        .base       (base),
        .walk_done  (walk_done),
        .walk_err   (walk_err),
        .dev_irq    (dev_irq),
        .cmd        (cmd),
        .status     (status),
        .walk_start (walk_start),
        .walk_ptr   (walk_ptr)
    );

    // Read mux over the register map.
    always_comb begin
        if (reg_addr[2])                 reg_rdata = ptr_rd;
        else if (reg_addr == OFS_CMD)    reg_rdata = {24'h0, cmd};
        else if (reg_addr == OFS_STAT)   reg_rdata = {24'h0, status};
        else                             reg_rdata = '0;
    end

    assign walk_dir = cmd[3];
    assign host_irq = dev_irq;

    // R1: unused command bits read as zero.
    assert_cmd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CMD) |-> ((reg_rdata & 32'hFFFF_FFF6) == 32'h0));
    // R5: pointer bits 1:0 read as zero.
    assert_ptr_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4) |-> (reg_rdata[1:0] == 2'b00));
    // R6: a byte-wide pointer read returns nothing above bit 7.
    assert_byte_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[2] && reg_size == 2'd0) |-> (reg_rdata[31:8] == 24'h0));
endmodule

// File: tb/test_bmd_regs.sv
// Self-checking bench: sweeps pointer widths/offsets and command values.
module test_bmd_regs;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        walk_start, walk_dir, host_irq;
    logic [31:0] walk_ptr;
    logic        walk_done = 1'b0, walk_err = 1'b0, dev_irq = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Bench model state.
    logic [31:0] m_ptr = '0, m_fetch = '0;
    logic [7:0]  m_cmd = '0;
    logic        m_act = 0;

    always #(PERIOD/2) clk = ~clk;

    bmd_regs i_bmd_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .walk_start(walk_start), .walk_dir(walk_dir), .walk_ptr(walk_ptr),
        .walk_done(walk_done), .walk_err(walk_err), .dev_irq(dev_irq),
        .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
        reg_addr = a; reg_size = s;
        #1 d = reg_rdata;
    endtask

    function automatic int nbytes(input logic [1:0] s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ptr_after(input logic [31:0] p, input int off,
                                              input logic [1:0] s, input logic [31:0] d);
        logic [31:0] r = p;
        for (int k = 0; k < 4; k++)
            if (k >= off && k < off + nbytes(s)) r[8*k +: 8] = d[8*(k-off) +: 8];
        r[1:0] = 2'b00;
        return r;
    endfunction

    function automatic logic [31:0] ptr_read(input logic [31:0] p, input int off, input logic [1:0] s);
        logic [31:0] m = (nbytes(s) == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*nbytes(s))) - 1);
        return (p >> (8*off)) & m;
    endfunction

    // Command write with model update and pulse/pointer checks.
    task automatic cmd_write(input logic [7:0] v, input string req);
        logic exp_pulse;
        logic [31:0] d;
        logic rise = v[0] && !m_cmd[0];
        exp_pulse = rise && !m_act;
        if (rise) m_fetch = m_ptr;
        if (exp_pulse) m_act = 1'b1;
        m_cmd = v & 8'h09;
        wr(3'd0, 2'd0, {24'h0, v});
        chk({req, " pulse"}, {31'h0, walk_start}, {31'h0, exp_pulse});
        chk({req, " walk_ptr"}, walk_ptr, m_fetch);
        rd(3'd0, 2'd2, d);
        chk("R1 cmd readback", d, {24'h0, m_cmd});
        chk("R1 walk_dir", {31'h0, walk_dir}, {31'h0, m_cmd[3]});
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state.
        rd(3'd0, 2'd2, d); chk("R10 cmd reset", d, 0);
        rd(3'd2, 2'd2, d); chk("R10 status reset", d, 0);
        rd(3'd4, 2'd2, d); chk("R10 ptr reset", d, 0);
        rd(3'd1, 2'd2, d); chk("R10 offset1 zero", d, 0);
        chk("R10 walk_start", {31'h0, walk_start}, 0);
        chk("R10 walk_ptr", walk_ptr, 0);

        // R5/R6: every width at every offset, then every read shape.
        for (int off = 0; off < 4; off++) begin
            for (int s = 0; s < 3; s++) begin
                logic [31:0] pat = 32'hA5C3_0F00 ^ (off * 32'h1111_1111) ^ (s * 32'h0101_0107) ^ 32'h0000_00FF;
                wr(3'(4 + off), 2'(s), pat);
                m_ptr = ptr_after(m_ptr, off, 2'(s), pat);
                for (int ro = 0; ro < 4; ro++)
                    for (int rs = 0; rs < 3; rs++) begin
                        rd(3'(4 + ro), 2'(rs), d);
                        chk("R5/R6 ptr lanes", d, ptr_read(m_ptr, ro, 2'(rs)));
                    end
            end
        end

        wr(3'd4, 2'd2, 32'h1234_567B);
        m_ptr = 32'h1234_5678;
        // R1/R2/R3: sweep every command byte.
        for (int v = 0; v < 256; v++) cmd_write(8'(v), "R3 sweep");

        // R2: same start value after pointer change: no reload, no pulse.
        wr(3'd4, 2'd2, 32'hCAFE_0010);
        m_ptr = 32'hCAFE_0010;
        cmd_write(8'h01, "R2 same start");
        // R4: clearing start keeps the transfer active until done.
        cmd_write(8'h00, "R4 stop");
        rd(3'd2, 2'd0, d); chk("R4 still active", d & 1, 1);
        @(negedge clk) walk_done = 1'b1;
        @(negedge clk) walk_done = 1'b0;
        m_act = 1'b0;
        rd(3'd2, 2'd0, d); chk("R4 cleared on done", d & 1, 0);
        cmd_write(8'h09, "R3 restart");

        // R9/R8: error set, write-1-clear and RW bits.
        @(negedge clk) walk_err = 1'b1;
        @(negedge clk) walk_err = 1'b0;
        rd(3'd2, 2'd0, d); chk("R9 err set", d, 32'h03);
        wr(3'd2, 2'd0, 32'hFF);
        rd(3'd2, 2'd0, d); chk("R8 w1c and rw", d, 32'h61);
        wr(3'd2, 2'd0, 32'h00);
        rd(3'd2, 2'd0, d); chk("R8 rw clear", d, 32'h01);
        @(negedge clk) begin walk_err = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h02; end
        @(negedge clk) begin walk_err = 1'b0; reg_wr = 1'b0; end
        rd(3'd2, 2'd0, d); chk("R9 set beats clear", d, 32'h03);
        wr(3'd2, 2'd0, 32'h02);

        // R7: interrupt forwarding and latch.
        @(negedge clk) dev_irq = 1'b1;
        #1 chk("R7 host_irq high", {31'h0, host_irq}, 1);
        @(negedge clk);
        rd(3'd2, 2'd0, d); chk("R7 int latched", d, 32'h05);
        dev_irq = 1'b0;
        #1 chk("R7 host_irq low", {31'h0, host_irq}, 0);
        @(negedge clk);
        rd(3'd2, 2'd0, d); chk("R7 fall keeps bit", d, 32'h05);
        wr(3'd2, 2'd0, 32'h04);
        rd(3'd2, 2'd0, d); chk("R8 int cleared", d, 32'h01);

        // R10: reset cancels an active transfer.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        rd(3'd2, 2'd2, d); chk("R10 active cancelled", d, 0);
        rd(3'd0, 2'd2, d); chk("R10 cmd cleared", d, 0);
        rd(3'd4, 2'd2, d); chk("R10 ptr cleared", d, 0);
        chk("R10 walk_ptr cleared", walk_ptr, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule